// File: doc/BRIEF.md
# Nibble Parity Encoder for Fuse Loading

This block converts a stream of data bytes into the protected format kept in a one-time-programmable fuse array. Every byte is cut into two 4-bit halves, and each half becomes an 8-bit codeword. The half's own bits sit unchanged in the low four bits of the codeword. Four parity bits sit above them, and each parity bit is the XOR of one pair of data bits. The two codewords of a byte go out one per clock on an array write port, at consecutive byte addresses.

A run starts with a one-cycle start pulse that gives the first array address and the number of bytes to load. Bytes then arrive over a valid/ready handshake. The block accepts a byte in one cycle and writes its upper codeword in the next, so ready is high on every second cycle at most and the write port is never idle while bytes keep coming. The write address counts modulo 1024. After the final codeword the block raises done for a single cycle and returns to idle.

Top module: `nibble_fuse_encoder`

## Requirements
- R1: Bits [3:0] of every codeword equal the data nibble d3..d0 it encodes.
- R2: Codeword bit 4 equals d0 XOR d1, and codeword bit 5 equals d2 XOR d3.
- R3: Codeword bit 6 equals d0 XOR d2, and codeword bit 7 equals d1 XOR d3.
- R4: The codeword of byte bits [3:0] is written in the cycle right after the byte is accepted. The codeword of bits [7:4] is written in the cycle after that.
- R5: The first write of a run goes to the start address. Each later write goes to the previous address plus one, across byte boundaries as well.
- R6: in_ready_o is high only in a run that is waiting for a byte. It is low in the cycle after a byte is accepted. When bytes are offered back to back, the writes of a run fall on consecutive cycles.
- R7: The write address is 10 bits wide and wraps from 0x3FF to 0x000.
- R8: A run of N bytes produces exactly 2N writes. done_o is high for exactly one cycle, in the cycle after the last write. With N = 0, done_o is high in the cycle right after the start is sampled, and no write occurs.
- R9: A start pulse during a run is ignored. The run keeps its address sequence and its byte count.
- R10: During and after reset, wr_en_o, in_ready_o and done_o are low. Offered bytes cause no write until a new start arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse that begins a run when idle |
| base_i | input | 10 | First array byte address of the run |
| count_i | input | 10 | Number of bytes in the run |
| in_valid_i | input | 1 | Byte on in_data_i is offered |
| in_data_i | input | 8 | Byte to encode |
| in_ready_o | output | 1 | Block accepts the offered byte this cycle |
| wr_en_o | output | 1 | Array write strobe |
| wr_addr_o | output | 10 | Array byte address of the write |
| wr_data_o | output | 8 | Codeword to store |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
Every output is registered. The low codeword is due one cycle after the accepting edge, and the high codeword two cycles after it. Done follows one cycle after the last write, or comes directly from the start edge for an empty run. The bench drives and samples on the falling edge. It logs each write together with the number of the rising edge that produced it. The checks compare those edge numbers with the edge that accepted the byte or sampled the start, so a late or early codeword shows up as a wrong edge number and not only as a wrong value.

// File: rtl/fenc_pkg.sv
package fenc_pkg;

    localparam int NIB_W  = 4;
    localparam int PAR_N  = 4;
    localparam int CW_W   = NIB_W + PAR_N;
    localparam int BYTE_W = 8;
    localparam int NIBS   = BYTE_W / NIB_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2,
        ST_FIN  = 2'd3
    } fenc_state_e;

    // First data bit feeding parity bit k
    function automatic int par_src_a(input int k);
        case (k)
            0:       return 0;
            1:       return 2;
            2:       return 0;
            default: return 1;
        endcase
    endfunction

    // Second data bit feeding parity bit k
    function automatic int par_src_b(input int k);
        case (k)
            0:       return 1;
            1:       return 3;
            2:       return 2;
            default: return 3;
        endcase
    endfunction

endpackage

// File: rtl/fenc_nibble_code.sv
module fenc_nibble_code
    import fenc_pkg::*;
(
    input  logic [NIB_W-1:0] nib_i,
    output logic [CW_W-1:0]  cw_o
);

    assign cw_o[NIB_W-1:0] = nib_i;

    for (genvar k = 0; k < PAR_N; k++) begin : g_par
        localparam int SA = par_src_a(k);
        localparam int SB = par_src_b(k);
        assign cw_o[NIB_W+k] = nib_i[SA] ^ nib_i[SB];
    end

endmodule

// File: rtl/fenc_seq.sv
module fenc_seq
    import fenc_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              in_valid_i,
    input  logic [CW_W-1:0]   lo_cw_i,
    input  logic [CW_W-1:0]   hi_cw_i,
    output logic              in_ready_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [CW_W-1:0]   wr_data_o,
    output logic              done_o
);

    typedef struct packed {
        fenc_state_e       st;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  left;
        logic [CW_W-1:0]   hi_cw;
        logic              wr_en;
        logic [ADDR_W-1:0] wr_addr;
        logic [CW_W-1:0]   wr_data;
        logic              done;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.wr_en   = 1'b0;
        s_d.done    = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.addr = base_i;
                    s_d.left = count_i;
                    if (count_i == '0) begin
                        s_d.done = 1'b1;
                    end else begin
                        s_d.st = ST_LOW;
                    end
                end
            end
            ST_LOW: begin
                if (in_valid_i) begin
                    s_d.wr_en   = 1'b1;
                    s_d.wr_addr = s_q.addr;
                    s_d.wr_data = lo_cw_i;
                    s_d.hi_cw   = hi_cw_i;
                    s_d.addr    = s_q.addr + 1'b1;
                    s_d.left    = s_q.left - 1'b1;
                    s_d.st      = ST_HIGH;
                end
            end
            ST_HIGH: begin
                s_d.wr_en   = 1'b1;
                s_d.wr_addr = s_q.addr;
                s_d.wr_data = s_q.hi_cw;
                s_d.addr    = s_q.addr + 1'b1;
                s_d.st      = (s_q.left == '0) ? ST_FIN : ST_LOW;
            end
            default: begin
                s_d.done = 1'b1;
                s_d.st   = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign in_ready_o = (s_q.st == ST_LOW);
    assign wr_en_o    = s_q.wr_en;
    assign wr_addr_o  = s_q.wr_addr;
    assign wr_data_o  = s_q.wr_data;
    assign done_o     = s_q.done;

    AST_ACCEPT_THEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o) |=> (wr_en_o && !in_ready_o)) else $error("ready after accept"); // R6

    AST_HIGH_ADDR_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o) |=> ##1 (wr_en_o && wr_addr_o == ADDR_W'($past(wr_addr_o) + 1'b1))) else $error("address step"); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o) else $error("done longer than one cycle"); // R8

    AST_DONE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!wr_en_o && !in_ready_o)) else $error("write with done"); // R8

endmodule

// File: rtl/nibble_fuse_encoder.sv
module nibble_fuse_encoder
    import fenc_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              in_valid_i,
    input  logic [BYTE_W-1:0] in_data_i,
    output logic              in_ready_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [CW_W-1:0]   wr_data_o,
    output logic              done_o
);

    logic [CW_W-1:0] cw [NIBS];

    for (genvar g = 0; g < NIBS; g++) begin : g_enc
        fenc_nibble_code u_code (
            .nib_i (in_data_i[g*NIB_W +: NIB_W]),
            .cw_o  (cw[g])
        );
    end

    fenc_seq #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .base_i     (base_i),
        .count_i    (count_i),
        .in_valid_i (in_valid_i),
        .lo_cw_i    (cw[0]),
        .hi_cw_i    (cw[NIBS-1]),
        .in_ready_o (in_ready_o),
        .wr_en_o    (wr_en_o),
        .wr_addr_o  (wr_addr_o),
        .wr_data_o  (wr_data_o),
        .done_o     (done_o)
    );

    AST_LOW_NIB_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o) |=> (wr_data_o[3:0] == $past(in_data_i[3:0]))) else $error("low nibble"); // R1

    AST_HIGH_NIB_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o) |=> ##1 (wr_data_o[3:0] == $past(in_data_i[7:4], 2))) else $error("high nibble order"); // R4

    AST_PAR_PAIRS_A: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (wr_data_o[4] == (wr_data_o[0] ^ wr_data_o[1]) &&
                     wr_data_o[5] == (wr_data_o[2] ^ wr_data_o[3]))) else $error("parity 4/5"); // R2

    AST_PAR_PAIRS_B: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (wr_data_o[6] == (wr_data_o[0] ^ wr_data_o[2]) &&
                     wr_data_o[7] == (wr_data_o[1] ^ wr_data_o[3]))) else $error("parity 6/7"); // R3

endmodule

// File: tb/nibble_fuse_encoder_bench.sv
`timescale 1ns/1ps
module nibble_fuse_encoder_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [9:0] base = '0;
    logic [9:0] count = '0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_ready, wr_en, done;
    logic [9:0] wr_addr;
    logic [7:0] wr_data;

    always #4 clk = ~clk;

    nibble_fuse_encoder u_nibble_fuse_encoder (
        .clk(clk), .rst_n(rst_n), .start_i(start), .base_i(base), .count_i(count),
        .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
        .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .done_o(done)
    );

    // {byte, codeword of bits[3:0], codeword of bits[7:4]}
    localparam logic [23:0] VEC [8] = '{
        24'h00_00_00, 24'h21_51_92, 24'h53_C3_35, 24'h84_64_A8,
        24'hFA_3A_0F, 24'h96_F6_F9, 24'hEC_CC_5E, 24'h07_A7_00
    };

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int nw = 0;
    int ndone = 0;
    int dcyc = 0;
    int s_edge = 0;
    logic [9:0] la [64];
    logic [7:0] ld [64];
    int         lc [64];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            if (nw < 64) begin
                la[nw] = wr_addr;
                ld[nw] = wr_data;
                lc[nw] = cyc;
            end
            nw = nw + 1;
        end
        if (rst_n && done) begin
            ndone = ndone + 1;
            dcyc  = cyc;
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog R8 actual=%0d expected=<20000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        nw = 0;
        ndone = 0;
        dcyc = 0;
    endtask

    task automatic go(input logic [9:0] b, input logic [9:0] n);
        start = 1'b1;
        base  = b;
        count = n;
        s_edge = cyc + 1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic push(input logic [7:0] b);
        in_valid = 1'b1;
        in_data  = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(in_ready == 1'b0, "R6 ready low after accept", in_ready, 0);
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R8 done single cycle", done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(wr_en == 1'b0, "R10 reset wr_en", wr_en, 0);
        chk(in_ready == 1'b0, "R10 reset ready", in_ready, 0);
        chk(done == 1'b0, "R10 reset done", done, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table run: R1 R2 R3 R4 R5 R6 R8
        clear_log();
        go(10'h010, 10'd8);
        for (int i = 0; i < 8; i++) push(VEC[i][23:16]);
        wait_done();
        chk(nw == 16, "R8 write count", nw, 16);
        for (int i = 0; i < 8; i++) begin
            chk(la[2*i] == 10'(10'h010 + 2*i), "R5 low address", la[2*i], 10'h010 + 2*i);
            chk(ld[2*i] == VEC[i][15:8], "R1 R2 R3 R4 low codeword", ld[2*i], VEC[i][15:8]);
            chk(la[2*i+1] == 10'(10'h011 + 2*i), "R5 high address", la[2*i+1], 10'h011 + 2*i);
            chk(ld[2*i+1] == VEC[i][7:0], "R1 R2 R3 R4 high codeword", ld[2*i+1], VEC[i][7:0]);
        end
        for (int j = 1; j < 16; j++)
            chk(lc[j] == lc[j-1] + 1, "R6 one codeword per clock", lc[j], lc[j-1] + 1);
        chk(ndone == 1, "R8 done count", ndone, 1);
        chk(dcyc == lc[15] + 1, "R8 done after last write", dcyc, lc[15] + 1);

        // Wrap: R7
        clear_log();
        go(10'h3FF, 10'd2);
        push(8'h21);
        push(8'h53);
        wait_done();
        chk(nw == 4, "R7 write count", nw, 4);
        chk(la[0] == 10'h3FF, "R7 first address", la[0], 10'h3FF);
        chk(la[1] == 10'h000, "R7 wrapped address", la[1], 10'h000);
        chk(la[3] == 10'h002, "R7 after wrap", la[3], 10'h002);
        chk(ld[1] == 8'h92 && ld[2] == 8'hC3, "R7 data across wrap", {ld[1], ld[2]}, 16'h92C3);

        // Empty run: R8
        clear_log();
        go(10'h123, 10'd0);
        repeat (4) @(negedge clk);
        chk(nw == 0, "R8 empty run writes", nw, 0);
        chk(ndone == 1, "R8 empty run done count", ndone, 1);
        chk(dcyc == s_edge, "R8 empty run done timing", dcyc, s_edge);

        // Start during a run: R9
        clear_log();
        go(10'h040, 10'd2);
        push(8'h84);
        start = 1'b1; base = 10'h200; count = 10'd5;
        @(negedge clk);
        start = 1'b0;
        push(8'hFA);
        wait_done();
        repeat (5) @(negedge clk);
        chk(nw == 4, "R9 write count kept", nw, 4);
        chk(la[2] == 10'h042 && la[3] == 10'h043, "R9 address kept", la[3], 10'h043);
        chk(ld[2] == 8'h3A && ld[3] == 8'h0F, "R9 data", {ld[2], ld[3]}, 16'h3A0F);
        chk(ndone == 1, "R9 single done", ndone, 1);

        // Reset in a run: R10
        go(10'h100, 10'd4);
        push(8'h21);
        rst_n = 1'b0;
        @(negedge clk);
        chk(wr_en == 1'b0 && in_ready == 1'b0 && done == 1'b0, "R10 reset mid run",
            {wr_en, in_ready, done}, 0);
        rst_n = 1'b1;
        clear_log();
        in_valid = 1'b1; in_data = 8'h53;
        repeat (4) @(negedge clk);
        chk(nw == 0, "R10 no write without start", nw, 0);
        chk(in_ready == 1'b0, "R10 ready idle", in_ready, 0);
        in_valid = 1'b0;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule